// File: doc/BRIEF.md
# Shared Instruction/Data Memory Port with Double-Rate Access

This block lets a single single-ported storage array serve both the instruction fetch and the data access of a processor in every processor cycle. It runs on a fast clock at twice the processor rate. An internal phase flag splits each processor cycle into two fast cycles. The first fast cycle reads the word at the fetch address. The second fast cycle either reads or writes the word at the data address.

Each 32-bit word sits in two 16-bit banks that share one address. The upper bank holds bits 31:16 and the lower bank holds bits 15:0. Each kind of read result lands in its own output register, so neither overwrites the other. Both results are valid once the processor cycle ends. The processor holds its fetch address, data address, write enable and write data steady for the whole processor cycle. It uses the phase output to see where each cycle begins.

Top module: `umem_port`

## Requirements
- R1: While reset is high, and on the first sample after it falls, the phase output is 0 and both the instruction and data outputs are zero.
- R2: The phase output is 0 (fetch phase) in the first fast cycle after reset. It then alternates between 0 and 1 on every fast clock edge.
- R3: On the clock edge that ends a fetch phase (phase 0), the instruction output loads the full word stored at the fetch address. It then holds that value through the following data phase.
- R4: On the clock edge that ends a data phase (phase 1) with the write enable low, the data output loads the word stored at the data address. The storage is left unchanged.
- R5: On the clock edge that ends a data phase with the write enable high, the write data is stored at the data address. On that same edge the data output returns the contents that location held before the write.
- R6: A write to the address fetched in the same processor cycle does not change that cycle's instruction output, which shows the old word. A fetch of that address in the next processor cycle returns the new word.
- R7: Bits 31:16 of a word are written and read back only as bits 31:16, and bits 15:0 only as bits 15:0. Words with unlike halves come back with the halves in place.
- R8: The instruction output changes only on edges that end a fetch phase. The data output changes only on edges that end a data phase.
- R9: A write enable that is high only during the fetch phase, and low again before the data phase ends, stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock, twice the processor rate |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | input | ADDR_W | Word address of the instruction to fetch |
| data_addr | input | ADDR_W | Word address of the data access |
| data_we | input | 1 | Write request for the data access |
| data_wdata | input | 2*HALF_W | Word to store on a write |
| phase_o | output | 1 | 0 in the fetch phase, 1 in the data phase |
| instr_o | output | 2*HALF_W | Captured instruction word |
| data_o | output | 2*HALF_W | Captured data read word |

## Verification
The bench first preloads the array with words whose two halves differ. Fetches then walk the addresses in order while data reads use pseudo-random addresses. This separates a correct address mux from one that swaps or merges the two addresses, and it exposes swapped halves.

Writes aimed at the address fetched in the same cycle show whether the fetch is ordered before the write. Writes aimed at the address read in the same cycle show the read-first return value.

A write enable that is pulsed only in the fetch phase shows whether writes are gated to the data phase. A model holding every word is compared with both outputs on every fast clock, so an output that moves in the wrong phase is caught.

// File: rtl/umem_pkg.sv
package umem_pkg;
  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;
endpackage

// File: rtl/umem_phase.sv
module umem_phase
  import umem_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e ph
);
  phase_e ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_FETCH;
    else     ph_q <= (ph_q == PH_FETCH) ? PH_DATA : PH_FETCH;
  end

  assign ph = ph_q;

  // R2: the phase alternates on every fast edge
  assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ph_q != $past(ph_q));
endmodule

// File: rtl/umem_mux.sv
module umem_mux
  import umem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 32
) (
  input  phase_e              ph,
  input  logic [ADDR_W-1:0]   fetch_addr,
  input  logic [ADDR_W-1:0]   data_addr,
  input  logic                data_we,
  input  logic [WORD_W-1:0]   data_wdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_we,
  output logic [WORD_W-1:0]   mem_wdata,
  output logic                cap_ins,
  output logic                cap_dat
);
  always_comb begin
    cap_ins   = (ph == PH_FETCH);
    cap_dat   = (ph == PH_DATA);
    mem_addr  = cap_dat ? data_addr : fetch_addr;
    mem_we    = cap_dat & data_we;
    mem_wdata = data_wdata;
  end
endmodule

// File: rtl/umem_bank.sv
module umem_bank #(
  parameter int ADDR_W = 6,
  parameter int WIDTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              cap_ins,
  input  logic              cap_dat,
  output logic [WIDTH-1:0]  ins_q,
  output logic [WIDTH-1:0]  dat_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // read-first capture: the old contents leave on a write edge
  always_ff @(posedge clk) begin
    if (rst) begin
      ins_q <= '0;
      dat_q <= '0;
    end else begin
      if (cap_ins) ins_q <= mem[addr];
      if (cap_dat) dat_q <= mem[addr];
    end
  end

  // R8: only one capture register is enabled per fast cycle
  assert_one_capture_R8: assert property (@(posedge clk) disable iff (rst)
    !(cap_ins && cap_dat));
endmodule

// File: rtl/umem_port.sv
module umem_port
  import umem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int HALF_W = 16
) (
  input  logic                clk2x,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   fetch_addr,
  input  logic [ADDR_W-1:0]   data_addr,
  input  logic                data_we,
  input  logic [2*HALF_W-1:0] data_wdata,
  output logic                phase_o,
  output logic [2*HALF_W-1:0] instr_o,
  output logic [2*HALF_W-1:0] data_o
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int NBANK  = 2;

  phase_e            ph;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [WORD_W-1:0] mem_wdata;
  logic              cap_ins;
  logic              cap_dat;

  umem_phase u_phase (
    .clk (clk2x),
    .rst (rst),
    .ph  (ph)
  );

  umem_mux #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mux (
    .ph         (ph),
    .fetch_addr (fetch_addr),
    .data_addr  (data_addr),
    .data_we    (data_we),
    .data_wdata (data_wdata),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .cap_ins    (cap_ins),
    .cap_dat    (cap_dat)
  );

  // bank 1 holds bits 31:16, bank 0 holds bits 15:0
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    umem_bank #(.ADDR_W(ADDR_W), .WIDTH(HALF_W)) u_bank (
      .clk     (clk2x),
      .rst     (rst),
      .addr    (mem_addr),
      .we      (mem_we),
      .wdata   (mem_wdata[b*HALF_W +: HALF_W]),
      .cap_ins (cap_ins),
      .cap_dat (cap_dat),
      .ins_q   (instr_o[b*HALF_W +: HALF_W]),
      .dat_q   (data_o[b*HALF_W +: HALF_W])
    );
  end

  assign phase_o = (ph == PH_DATA);

  // R9: the array is written only in the data phase
  assert_we_phase_R9: assert property (@(posedge clk2x) disable iff (rst)
    mem_we |-> phase_o);
  // R3: the fetch phase addresses the array with the fetch address
  assert_fetch_addr_R3: assert property (@(posedge clk2x) disable iff (rst)
    !phase_o |-> mem_addr == fetch_addr);
  // R4: the data phase addresses the array with the data address
  assert_data_addr_R4: assert property (@(posedge clk2x) disable iff (rst)
    phase_o |-> mem_addr == data_addr);
  // R8: the instruction output holds across data-phase edges
  assert_instr_hold_R8: assert property (@(posedge clk2x) disable iff (rst)
    phase_o |=> $stable(instr_o));
  // R8: the data output holds across fetch-phase edges
  assert_data_hold_R8: assert property (@(posedge clk2x) disable iff (rst)
    !phase_o |=> $stable(data_o));
endmodule

// File: tb/sim_umem_port.sv
`timescale 1ns/1ps
module sim_umem_port;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk2x = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] fetch_addr = '0;
  logic [AW-1:0] data_addr = '0;
  logic          data_we = 1'b0;
  logic [31:0]   data_wdata = '0;
  logic          phase_o;
  logic [31:0]   instr_o;
  logic [31:0]   data_o;

  always #5 clk2x = ~clk2x;

  umem_port #(.ADDR_W(AW), .HALF_W(16)) u0 (
    .clk2x      (clk2x),
    .rst        (rst),
    .fetch_addr (fetch_addr),
    .data_addr  (data_addr),
    .data_we    (data_we),
    .data_wdata (data_wdata),
    .phase_o    (phase_o),
    .instr_o    (instr_o),
    .data_o     (data_o)
  );

  logic [31:0] model [DEPTH];
  logic [31:0] exp_i = '0;
  logic [31:0] exp_d = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one processor cycle; called at a negedge that precedes a fetch-phase edge
  task automatic pcycle(input logic [AW-1:0] fa, input logic [AW-1:0] da,
                        input logic we, input logic [31:0] wd, input string req);
    logic [31:0] nxt_i;
    logic [31:0] nxt_d;
    fetch_addr = fa; data_addr = da; data_we = we; data_wdata = wd;
    nxt_i = model[fa];
    nxt_d = model[da];
    @(posedge clk2x); @(negedge clk2x);
    exp_i = nxt_i;
    if (chk_on) begin
      check("R2", {31'd0, phase_o}, 32'd1);
      check({req, "/R3"}, instr_o, exp_i);
      check("R8", data_o, exp_d);
    end
    @(posedge clk2x); @(negedge clk2x);
    exp_d = nxt_d;
    if (we) model[da] = wd;
    if (chk_on) begin
      check("R2", {31'd0, phase_o}, 32'd0);
      check({req, "/R4"}, data_o, exp_d);
      check("R8", instr_o, exp_i);
    end
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk2x);
    // R1: reset state
    check("R1", {31'd0, phase_o}, 32'd0);
    check("R1", instr_o, 32'd0);
    check("R1", data_o, 32'd0);
    rst = 1'b0;
    check("R1", {31'd0, phase_o}, 32'd0);
    check("R1", data_o, 32'd0);

    // preload with unlike halves (R7); outputs not checked while array unknown
    for (int i = 0; i < DEPTH; i++)
      pcycle(AW'(0), AW'(i), 1'b1, {16'hA500 | 16'(i), 16'h5A00 ^ 16'(i * 3)}, "R5");
    chk_on = 1'b1;
    exp_i = instr_o;
    exp_d = data_o;

    // sequential fetch, pseudo-random data reads (R3, R4, R7)
    lcg = 32'h1234_5678;
    for (int i = 0; i < DEPTH; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      pcycle(AW'(i), AW'(lcg[15:10]), 1'b0, '0, "R7");
    end

    // write with read-first return (R5)
    pcycle(AW'(1), AW'(9), 1'b1, 32'hDEAD_BEEF, "R5");
    pcycle(AW'(2), AW'(9), 1'b0, '0, "R5");
    check("R5", data_o, 32'hDEAD_BEEF);

    // write to the address fetched in the same cycle (R6)
    pcycle(AW'(20), AW'(20), 1'b1, 32'h1357_2468, "R6");
    check("R6", instr_o, {16'hA500 | 16'd20, 16'h5A00 ^ 16'd60});
    pcycle(AW'(20), AW'(3), 1'b0, '0, "R6");
    check("R6", instr_o, 32'h1357_2468);

    // halves kept apart (R7)
    pcycle(AW'(0), AW'(33), 1'b1, 32'h0000_FFFF, "R7");
    pcycle(AW'(33), AW'(33), 1'b0, '0, "R7");
    check("R7", instr_o, 32'h0000_FFFF);
    check("R7", data_o, 32'h0000_FFFF);

    // write enable only in fetch phase (R9)
    fetch_addr = AW'(5); data_addr = AW'(40); data_wdata = 32'hBAD0_BAD0; data_we = 1'b1;
    @(posedge clk2x); @(negedge clk2x);
    data_we = 1'b0;
    exp_i = model[5];
    check("R3", instr_o, exp_i);
    @(posedge clk2x); @(negedge clk2x);
    exp_d = model[40];
    check("R9", data_o, exp_d);
    pcycle(AW'(40), AW'(40), 1'b0, '0, "R9");
    check("R9", instr_o, model[40]);

    // mixed traffic against the model
    for (int i = 0; i < 200; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      pcycle(AW'(lcg[31:26]), AW'(lcg[25:20]), lcg[3], lcg ^ 32'h0F0F_3C3C, "R5");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule